// File: doc/BRIEF.md
# Sticky Interrupt Cause Aggregator

This block gathers single-cycle event pulses from up to 32 sources of a link receiver into sticky cause bits and presents them to a host through a small word-addressed register interface. The host reads the cause register to learn what happened, and that read empties it. Any write to the cause register is not a legal operation, and it empties the register as well. A mask register selects which pending causes may raise the single host interrupt line. All sources start masked, so the host must open the mask on purpose.

Beside these sits a two-bit status register fed by its own pair of event pulses. Each bit is set by its event and cleared only when the host writes a 1 to that bit position. Some cause positions are reserved by a parameter. They never latch and always read as zero.

The register map uses word indices 0 for the cause register, 1 for the mask and 2 for the status register. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_cause_unit`

## Requirements
- R1: A pulse on a non-reserved event input sets the matching cause bit at the next clock edge, and the bit stays set through any number of idle cycles until a clear.
- R2: A read of the cause register (address 0) returns the bits pending before the read, and every cause bit is zero afterwards unless an event arrived with the read.
- R3: A write to the cause register clears every cause bit whatever the write data is.
- R4: After reset the mask register (address 1) reads all ones, the cause register and status register read zero, and the interrupt output is low even when events arrive.
- R5: The interrupt output is high one cycle after any cause bit is set whose mask bit is 0, and low one cycle after no such bit exists.
- R6: Cause bits at positions set in the reserved parameter never latch and always read 0.
- R7: Status register (address 2) bit 0 and bit 1 are set by their status event inputs. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: An event arriving in the same cycle as a cause clear, or a status event arriving with a write-one clear, wins: the bit ends set and shows on the next read.
- R9: regRdData is updated one cycle after regRdEn and is 0 in the cycles after no read. A read of an unmapped address returns 0, and the mask reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evIn | input | NUM_SRC | Single-cycle cause event pulses |
| stsEvIn | input | 2 | Single-cycle status event pulses |
| regAddr | input | ADDR_W | Register word index |
| regRdEn | input | 1 | Read strobe |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Registered read data |
| irqOut | output | 1 | Registered host interrupt |

## Verification
The assertions assume that regRdEn and regWrEn are never raised in the same cycle. They also assume that event inputs are free of X after reset. The stimulus drives every strobe for exactly one cycle and never overlaps a read with a write. The stimulus sweeps all event patterns and all mask values on an 8-source configuration with two reserved positions, and raises events alongside clears only in the dedicated collision cases.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int STS_W = 2;
  localparam int ADDR_CAUSE = 0;
  localparam int ADDR_MASK  = 1;
  localparam int ADDR_STS   = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_MASK,
    SEL_STS
  } rdSel_e;

  typedef struct packed {
    logic             causeClr;
    logic             maskWr;
    logic [STS_W-1:0] stsClr;
    logic             rdLoad;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [STS_W-1:0]  wrLow,
  output strobe_t           stb
);
  logic hitCause, hitMask, hitSts;

  assign hitCause = (regAddr == ADDR_W'(ADDR_CAUSE));
  assign hitMask  = (regAddr == ADDR_W'(ADDR_MASK));
  assign hitSts   = (regAddr == ADDR_W'(ADDR_STS));

  always_comb begin
    stb          = '0;
    stb.causeClr = hitCause && (regRdEn || regWrEn);
    stb.maskWr   = hitMask && regWrEn;
    stb.stsClr   = (hitSts && regWrEn) ? wrLow : '0;
    stb.rdLoad   = regRdEn;
    if (regRdEn) begin
      if (hitCause)      stb.rdSel = SEL_CAUSE;
      else if (hitMask)  stb.rdSel = SEL_MASK;
      else if (hitSts)   stb.rdSel = SEL_STS;
      else               stb.rdSel = SEL_NONE;
    end
  end

  // R9: a write aimed elsewhere never disturbs the mask or status registers
  p_write_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !hitMask && !hitSts) |-> (!stb.maskWr && stb.stsClr == '0));

  // R3: a write to the cause register always yields a clear
  p_write_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && hitCause) |-> stb.causeClr);
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter logic [NUM_SRC-1:0] RSVD_BITS = NUM_SRC'('hA0)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evIn,
  input  logic [STS_W-1:0]   stsEvIn,
  input  logic [DATA_W-1:0]  wrData,
  input  strobe_t            stb,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  localparam logic [NUM_SRC-1:0] LIVE = ~RSVD_BITS;

  logic [NUM_SRC-1:0] causeQ, causeNext, maskQ;
  logic [STS_W-1:0]   stsQ, stsNext;
  logic [DATA_W-1:0]  rdQ, rdNext;
  logic               irqQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cause
    if (LIVE[i]) begin : g_live
      assign causeNext[i] = evIn[i] | (causeQ[i] & ~stb.causeClr);
    end else begin : g_rsvd
      assign causeNext[i] = 1'b0;
    end
  end

  for (genvar b = 0; b < STS_W; b++) begin : g_sts
    assign stsNext[b] = stsEvIn[b] | (stsQ[b] & ~stb.stsClr[b]);
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdLoad) begin
      unique case (stb.rdSel)
        SEL_CAUSE: rdNext[NUM_SRC-1:0] = causeQ;
        SEL_MASK:  rdNext[NUM_SRC-1:0] = maskQ;
        SEL_STS:   rdNext[STS_W-1:0]   = stsQ;
        default:   rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '1;
      stsQ   <= '0;
      rdQ    <= '0;
      irqQ   <= 1'b0;
    end else begin
      causeQ <= causeNext;
      if (stb.maskWr) maskQ <= wrData[NUM_SRC-1:0];
      stsQ   <= stsNext;
      rdQ    <= rdNext;
      irqQ   <= |(causeQ & ~maskQ);
    end
  end

  assign rdData = rdQ;
  assign irqOut = irqQ;

  p_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.causeClr |=> ((causeQ & $past(causeQ)) == $past(causeQ)));

  p_clear_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.causeClr |=> ((causeQ & ~$past(evIn)) == '0));

  p_mask_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (maskQ == '1));

  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((causeQ & ~maskQ) == '0) |=> !irqOut);

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((causeQ & ~maskQ) != '0) |=> irqOut);

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (causeQ & RSVD_BITS) == '0);

  p_sts_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stsQ & $past(stsQ & ~stb.stsClr)) == $past(stsQ & ~stb.stsClr)));

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((evIn & LIVE) != '0) |=> ((causeQ & $past(evIn & LIVE)) == $past(evIn & LIVE)));

  p_idle_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdLoad |=> (rdData == '0));
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter logic [NUM_SRC-1:0] RSVD_BITS = NUM_SRC'('hA0)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evIn,
  input  logic [STS_W-1:0]   stsEvIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regRdEn,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  strobe_t stb;

  irqc_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regRdEn (regRdEn),
    .regWrEn (regWrEn),
    .wrLow   (regWrData[STS_W-1:0]),
    .stb     (stb)
  );

  irqc_datapath #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .RSVD_BITS (RSVD_BITS)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evIn    (evIn),
    .stsEvIn (stsEvIn),
    .wrData  (regWrData),
    .stb     (stb),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/test_irq_cause_unit.sv
`timescale 1ns/1ps
module test_irq_cause_unit;
  localparam int NS = 8;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [NS-1:0] RSVD = 8'hA0;
  localparam logic [NS-1:0] LIVE = ~RSVD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] evIn = '0;
  logic [1:0] stsEvIn = '0;
  logic [AW-1:0] regAddr = '0;
  logic regRdEn = 1'b0, regWrEn = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic irqOut;
  int cmpCnt = 0, errCnt = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  irq_cause_unit #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW), .RSVD_BITS(RSVD)) i_irq_cause_unit (
    .clk(clk), .rstN(rstN), .evIn(evIn), .stsEvIn(stsEvIn), .regAddr(regAddr),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    cmpCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    regAddr = AW'(a); regRdEn = 1'b1;
    tick();
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    regAddr = AW'(a); regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [NS-1:0] v);
    evIn = v;
    tick();
    evIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R4 / R9 reset state
    chk("R9 idle rdData", regRdData, '0);
    chk("R4 irq after reset", {31'b0, irqOut}, '0);
    rd(1, d); chk("R4 mask reset", d, 32'hFF);
    rd(0, d); chk("R4 cause reset", d, '0);
    rd(2, d); chk("R4 status reset", d, '0);
    tick();
    chk("R9 rdData back to 0", regRdData, '0);
    pulse('1); tick();
    chk("R4 masked irq low", {31'b0, irqOut}, '0);
    rd(0, d); chk("R6 reserved read 0", d, 32'(LIVE));

    // R1 R2 R6 sweep over every event pattern
    for (int v = 0; v < 256; v++) begin
      pulse(NS'(v));
      tick(); tick();
      rd(0, d); chk("R1 sticky cause", d, 32'(NS'(v) & LIVE));
      rd(0, d); chk("R2 cleared by read", d, '0);
    end

    // R3 write clears regardless of data
    pulse(8'h1F); wr(0, 32'h0); rd(0, d); chk("R3 write 0 clears", d, '0);
    pulse(8'h5F); wr(0, 32'hFF); rd(0, d); chk("R3 write ones clears", d, '0);

    // R5 and R9 mask sweep
    for (int m = 0; m < 256; m++) begin
      wr(1, 32'(m));
      rd(1, d); chk("R9 mask readback", d, 32'(m));
      pulse('1);
      tick();
      chk("R5 irq level", {31'b0, irqOut}, {31'b0, |(LIVE & ~NS'(m))});
      wr(0, '0);
      tick();
      chk("R5 irq drops", {31'b0, irqOut}, '0);
    end
    wr(1, '0);

    // R8 event wins over read clear
    pulse(8'h01);
    regAddr = '0; regRdEn = 1'b1; evIn = 8'h02;
    tick();
    regRdEn = 1'b0; evIn = '0;
    chk("R8 read shows old", regRdData, 32'h01);
    rd(0, d); chk("R8 event kept", d, 32'h02);

    // R8 event wins over write clear
    regAddr = '0; regWrEn = 1'b1; evIn = 8'h04;
    tick();
    regWrEn = 1'b0; evIn = '0;
    rd(0, d); chk("R8 event beats write", d, 32'h04);

    // R7 status write-one-clear
    stsEvIn = 2'b11; tick(); stsEvIn = '0;
    rd(2, d); chk("R7 status set", d, 32'h3);
    wr(2, 32'h1); rd(2, d); chk("R7 clear bit0", d, 32'h2);
    wr(2, 32'h0); rd(2, d); chk("R7 write 0 keeps", d, 32'h2);
    regAddr = 2; regWrData = 32'h2; regWrEn = 1'b1; stsEvIn = 2'b10;
    tick();
    regWrEn = 1'b0; stsEvIn = '0; regWrData = '0;
    rd(2, d); chk("R8 status event wins", d, 32'h2);
    wr(2, 32'h3); rd(2, d); chk("R7 clear both", d, '0);

    // R9 unmapped address
    pulse(8'h0F);
    rd(7, d); chk("R9 unmapped reads 0", d, '0);
    rd(0, d); chk("R9 unmapped read no clear", d, 32'h0F);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end
endmodule